// File: doc/BRIEF.md
# Pulse Interval Meter

This block counts the clock cycles that pass between consecutive events on a pulse line that is not related to the system clock. The raw line first goes through a two-flop synchronizer. An edge detector then turns each selected transition into a single-cycle event. A parameter picks the transitions that count: rising only (the default), falling only, or both.

Every event reloads a free-running counter with 1. On that same clock edge, a capture register stores the count the counter held just before the reload. The captured number is therefore the full, inclusive length of the interval that has just ended. No extra cycle and no timing trick is needed, because both actions are plain synchronous updates on one edge.

A small control machine tracks three phases:
- `ST_ARM` waits for the first event after reset.
- `ST_RUN` measures an interval.
- `ST_SAT` means the counter has stopped at its all-ones ceiling.

The machine has four transitions:
- *arm→run* on the first event. Nothing is reported for this event.
- *run→run* on each later event. This captures an interval.
- *run→sat* when the counter sits at all ones with no event present.
- *sat→run* on the next event. This captures the saturated value.

Top module: `pulse_interval_meter`

## Requirements
- R1: The pulse input reaches the logic only through a two-flop synchronizer. A transition driven just before clock edge k is captured at edge k+2, and the valid strobe is high in the cycle after edge k+2.
- R2: With the default edge selection, only rising transitions are events, so a pulse held high for several cycles counts once. With edge selection set to both, every rising and every falling transition is an event.
- R3: On an event the counter is loaded synchronously with 1. On the same edge the capture output takes the pre-load count. With the count enable held high, the captured value equals the number of clock cycles between the two events.
- R4: While the count enable is low and no event is present, the counter holds. Each enabled cycle adds one, so the capture equals the event spacing minus the number of disabled cycles.
- R5: The valid strobe is high for exactly one cycle per captured interval, in the cycle after the capture edge.
- R6: After reset, the first event only starts a measurement and raises no valid strobe. The same holds after a reset in the middle of a measurement.
- R7: The counter stops at all ones if no event arrives. The next event then captures the all-ones value.
- R8: The overflow flag rises in the cycle after the counter reaches all ones, stays high until the next capture, and is low in the cycle after that capture.
- R9: The terminal-count output is high exactly while the counter holds all ones. The carry output is high only when terminal count and count enable are both high.
- R10: During reset, the captured interval is 0 and the valid strobe, terminal count, carry and overflow outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Global reset, active low |
| pulse_i | input | 1 | Asynchronous pulse line |
| cnt_en_i | input | 1 | Count enable |
| interval_o | output | CNT_W | Last captured interval in cycles |
| interval_vld_o | output | 1 | One-cycle strobe after each capture |
| term_cnt_o | output | 1 | Counter holds all ones |
| carry_o | output | 1 | Terminal count ANDed with count enable |
| ovf_o | output | 1 | Sticky overflow, cleared by the next capture |

## Verification
Two functions can meet on one edge. The counter reload and the capture both act on a single event edge, so the capture must see the old count while the counter takes 1. Separately, an event can arrive on the very cycle the counter sits at its ceiling, and then saturation must hand its value over to the capture. The bench provokes the first with back-to-back pulse spacings as small as two cycles, and judges it by comparing each strobed value against the spacing it drove. It provokes the second by stretching one interval past the ceiling of a 5-bit counter, then checks the captured all-ones value together with the overflow flag before and after that edge.

// File: rtl/pim_pkg.sv
package pim_pkg;

    // Which synchronized transitions count as events
    typedef enum logic [1:0] {
        EDGE_RISE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_sel_e;

    // Measurement control phases
    typedef enum logic [1:0] {
        ST_ARM = 2'd0,
        ST_RUN = 2'd1,
        ST_SAT = 2'd2
    } meas_state_e;

endpackage

// File: rtl/pim_sync.sv
// Multi-flop synchronizer for a single asynchronous bit.
module pim_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("pim_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[LAST-1:0], async_i};
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/pim_edge.sv
// Turns selected transitions of a synchronized level into one-cycle events.
module pim_edge
    import pim_pkg::*;
#(
    parameter edge_sel_e EDGE_SEL = EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic evt_o
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= level_i;
        end
    end

    generate
        if (EDGE_SEL == EDGE_FALL) begin : g_fall
            assign evt_o = prev_q & ~level_i;
        end else if (EDGE_SEL == EDGE_BOTH) begin : g_both
            assign evt_o = prev_q ^ level_i;
        end else begin : g_rise
            assign evt_o = level_i & ~prev_q;
        end
    endgenerate

endmodule

// File: rtl/pim_counter.sv
// Interval counter: synchronous reload to one, gated increment, saturation.
module pim_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             cnt_en_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             term_cnt_o,
    output logic             carry_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic             at_max;
    logic             step;

    assign at_max = (cnt_q == CNT_MAX);
    assign step   = run_i & cnt_en_i & ~at_max;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CNT_ONE;
        end else if (step) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt_o      = cnt_q;
    assign term_cnt_o = at_max;
    assign carry_o    = at_max & cnt_en_i;

endmodule

// File: rtl/pulse_interval_meter.sv
// Pulse interval meter top: synchronizer, edge detector, counter, capture, control.
module pulse_interval_meter
    import pim_pkg::*;
#(
    parameter int        CNT_W       = 32,
    parameter int        SYNC_STAGES = 2,
    parameter edge_sel_e EDGE_SEL    = EDGE_RISE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    input  logic             cnt_en_i,
    output logic [CNT_W-1:0] interval_o,
    output logic             interval_vld_o,
    output logic             term_cnt_o,
    output logic             carry_o,
    output logic             ovf_o
);
    logic             pulse_sync;
    logic             evt;
    logic [CNT_W-1:0] cnt_q;
    logic             at_max;
    meas_state_e      state_q;
    meas_state_e      state_d;
    logic             capture_en;
    logic             run_en;
    logic             sat_flag;

    pim_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pulse_i),
        .sync_o  (pulse_sync)
    );

    pim_edge #(.EDGE_SEL(EDGE_SEL)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pulse_sync),
        .evt_o   (evt)
    );

    pim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (evt),
        .run_i      (run_en),
        .cnt_en_i   (cnt_en_i),
        .cnt_o      (cnt_q),
        .term_cnt_o (at_max),
        .carry_o    (carry_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM: if (evt) state_d = ST_RUN;
            ST_RUN: begin
                if (evt)         state_d = ST_RUN;
                else if (at_max) state_d = ST_SAT;
            end
            ST_SAT: if (evt) state_d = ST_RUN;
            default: state_d = ST_ARM;
        endcase
    end

    // Decoded controls
    always_comb begin
        capture_en = 1'b0;
        run_en     = 1'b0;
        sat_flag   = 1'b0;
        unique case (state_q)
            ST_ARM: ;
            ST_RUN: begin
                capture_en = evt;
                run_en     = 1'b1;
            end
            ST_SAT: begin
                capture_en = evt;
                run_en     = 1'b1;
                sat_flag   = 1'b1;
            end
            default: ;
        endcase
    end

    // Capture register and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            interval_o     <= '0;
            interval_vld_o <= 1'b0;
        end else begin
            interval_vld_o <= capture_en;
            if (capture_en) begin
                interval_o <= cnt_q;
            end
        end
    end

    assign term_cnt_o = at_max;
    assign ovf_o      = sat_flag;

endmodule

// File: rtl/pim_checker.sv
module pim_checker
    import pim_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_i,
    input meas_state_e      state_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] interval_i,
    input logic             vld_i,
    input logic             ovf_i,
    input logic             tc_i
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    assert_reload_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_i) |-> (cnt_i == ONE));

    assert_capture_prev_R3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> (interval_i == $past(cnt_i)));

    assert_vld_from_evt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> $past(evt_i));

    assert_no_vld_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_i) == ST_ARM) |-> !vld_i);

    assert_sat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_i && !evt_i) |=> tc_i);

    assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> !ovf_i);

    assert_ovf_at_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |-> tc_i);

endmodule

bind pulse_interval_meter pim_checker #(.CNT_W(CNT_W)) u_pim_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .state_i    (state_q),
    .cnt_i      (cnt_q),
    .interval_i (interval_o),
    .vld_i      (interval_vld_o),
    .ovf_i      (ovf_o),
    .tc_i       (term_cnt_o)
);

// File: tb/tb_pulse_interval_meter.sv
module tb_pulse_interval_meter;
    import pim_pkg::*;

    localparam int W       = 5;
    localparam int SAT_VAL = 31;
    localparam int NGAP    = 8;
    localparam int GAPS [NGAP] = '{5, 3, 10, 2, 17, 7, 4, 9};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pa = 1'b0;
    logic pb = 1'b0;
    logic en = 1'b1;

    logic [W-1:0] iv_a, iv_b;
    logic vld_a, tc_a, cy_a, ov_a;
    logic vld_b, tc_b, cy_b, ov_b;

    always #10 clk = ~clk;

    pulse_interval_meter #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .pulse_i(pa), .cnt_en_i(en),
        .interval_o(iv_a), .interval_vld_o(vld_a), .term_cnt_o(tc_a),
        .carry_o(cy_a), .ovf_o(ov_a)
    );

    pulse_interval_meter #(.CNT_W(W), .EDGE_SEL(EDGE_BOTH)) dut_both (
        .clk(clk), .rst_n(rst_n), .pulse_i(pb), .cnt_en_i(en),
        .interval_o(iv_b), .interval_vld_o(vld_b), .term_cnt_o(tc_b),
        .carry_o(cy_b), .ovf_o(ov_b)
    );

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int cap_n = 0;
    int cap_mem [128];
    int capb_n = 0;
    int capb_mem [16];

    always @(negedge clk) begin
        if (vld_a) begin
            if (cap_n < 128) cap_mem[cap_n] = int'(iv_a);
            cap_n = cap_n + 1;
        end
        if (vld_b) begin
            if (capb_n < 16) capb_mem[capb_n] = int'(iv_b);
            capb_n = capb_n + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int last_cap();
        if (cap_n == 0 || cap_n > 128) return -1;
        return cap_mem[cap_n-1];
    endfunction

    // Rising edge, high for hi cycles, next call starts gap cycles after this one
    task automatic pulse_a(input int hi, input int gap);
        @(negedge clk) pa = 1'b1;
        repeat (hi) @(negedge clk);
        pa = 1'b0;
        repeat (gap - hi - 1) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check(iv_a == '0, "R10 interval in reset", int'(iv_a), 0);
        check(!vld_a, "R10 valid in reset", int'(vld_a), 0);
        check(!tc_a, "R10 term count in reset", int'(tc_a), 0);
        check(!cy_a, "R10 carry in reset", int'(cy_a), 0);
        check(!ov_a, "R10 overflow in reset", int'(ov_a), 0);
        rst_n = 1'b1;

        // R6: first event after reset gives no strobe; R2: wide pulse counts once
        base = cap_n;
        pulse_a(3, 8);
        repeat (6) @(negedge clk);
        check(cap_n == base, "R6 no strobe on first event", cap_n - base, 0);
        pulse_a(1, 5);
        check(last_cap() == 14, "R2 wide pulse single event R3", last_cap(), 14);

        // Table of spacings: each capture equals the spacing driven (R3, R5)
        base = cap_n;
        for (int i = 0; i < NGAP; i++) pulse_a(1, GAPS[i]);
        pulse_a(1, 6);
        check(cap_n - base == NGAP + 1, "R5 one strobe per capture", cap_n - base, NGAP + 1);
        for (int i = 0; i < NGAP; i++) begin
            if (base + 1 + i < 128)
                check(cap_mem[base+1+i] == GAPS[i], "R3 table interval",
                      cap_mem[base+1+i], GAPS[i]);
        end

        // R1: synchronizer latency
        @(negedge clk) pa = 1'b1;
        @(negedge clk) pa = 1'b0;
        check(!vld_a, "R1 no strobe after edge k", int'(vld_a), 0);
        @(negedge clk);
        check(!vld_a, "R1 no strobe after edge k+1", int'(vld_a), 0);
        @(negedge clk);
        check(vld_a, "R1 strobe after edge k+2", int'(vld_a), 1);
        repeat (4) @(negedge clk);

        // R4: count enable low for 4 of 12 cycles
        @(negedge clk) pa = 1'b1;
        @(negedge clk) pa = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b0;
        repeat (4) @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        pulse_a(1, 6);
        check(last_cap() == 8, "R4 gated count", last_cap(), 8);
        check(!ov_a, "R8 overflow low in normal run", int'(ov_a), 0);

        // R7/R8/R9: saturation over a 40-cycle gap
        @(negedge clk) pa = 1'b1;
        @(negedge clk) pa = 1'b0;
        repeat (36) @(negedge clk);
        check(ov_a, "R8 overflow set at ceiling", int'(ov_a), 1);
        check(tc_a, "R9 term count at ceiling", int'(tc_a), 1);
        check(cy_a, "R9 carry with enable", int'(cy_a), 1);
        en = 1'b0;
        @(negedge clk);
        check(!cy_a, "R9 carry without enable", int'(cy_a), 0);
        check(tc_a, "R7 counter held at ceiling", int'(tc_a), 1);
        en = 1'b1;
        @(negedge clk);
        pulse_a(1, 6);
        check(last_cap() == SAT_VAL, "R7 saturated capture", last_cap(), SAT_VAL);
        check(!ov_a, "R8 overflow cleared by capture", int'(ov_a), 0);
        check(!tc_a, "R9 term count after reload", int'(tc_a), 0);

        // R2: both-edge variant, high 3 / low 6
        @(negedge clk) pb = 1'b1;
        repeat (3) @(negedge clk);
        pb = 1'b0;
        repeat (6) @(negedge clk);
        pb = 1'b1;
        repeat (3) @(negedge clk);
        pb = 1'b0;
        repeat (6) @(negedge clk);
        pb = 1'b1;
        repeat (6) @(negedge clk);
        check(capb_n == 4, "R2 both-edge capture count", capb_n, 4);
        for (int i = 0; i < 4; i++) begin
            if (i < capb_n)
                check(capb_mem[i] == ((i % 2 == 0) ? 3 : 6), "R2 both-edge interval",
                      capb_mem[i], (i % 2 == 0) ? 3 : 6);
        end

        // R6: reset during a measurement, then one event gives no strobe
        @(negedge clk) pa = 1'b1;
        @(negedge clk) pa = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        base = cap_n;
        pulse_a(1, 6);
        repeat (4) @(negedge clk);
        check(cap_n == base, "R6 no strobe after mid reset", cap_n - base, 0);
        pulse_a(1, 6);
        check(last_cap() == 10, "R6 measurement after reset R3", last_cap(), 10);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule